// File: doc/BRIEF.md
# Interleaved memory range decoder

This block claims a contiguous address window for host-managed device memory and spreads that window across up to sixteen interleave ways. Software sets up a window start, a window length, a control word (granule code, way-count code, lock, commit request and target class) and a packed list of eight one-byte port identifiers. It then raises the commit request. The block checks the settings and answers with either a committed flag or an error flag.

After a successful commit, each address presented on the lookup port is compared against the window. For an address inside the window, the block returns a hit, the interleave way that owns the address, the port identifier for that way, and the target class. The way count may be a power of two or three times a power of two. The three-based counts use a real remainder by three, not a bit slice. Once the window is committed and locked, the setup cannot change until reset.

Top module: `imd_decoder`

## Requirements
- R1: The interleave granule is 256 bytes shifted left by the granule code held in control bits [3:0]. The chunk index of an address is (address − start) divided by the granule.
- R2: The way code in control bits [7:4] gives 1, 2, 4, 8 or 16 ways for codes 0 to 4, and 3, 6 or 12 ways for codes 8, 9 and 10. Any other code is invalid: a commit with it fails, and it never yields a hit.
- R3: While the committed flag (control bit 11) is clear, `lk_hit` stays low for every address.
- R4: An address hits when start ≤ address ≤ start + length − 1. The lookup result appears on the cycle after `lk_valid` is sampled, and a miss drives way, target and class to zero.
- R5: A control write that raises the commit request (bit 9 from 0 to 1) sets committed (bit 11) on the next cycle when the settings are valid. Otherwise it sets error (bit 12) and leaves committed clear. The settings are invalid when the way code is invalid, or when the start or the length is all ones across the address width.
- R6: While unlocked, a control write with bit 9 clear clears both committed and error.
- R7: The lock bit (control bit 8) takes effect only while committed. While locked, writes to all four registers are ignored, and the block stays locked until reset.
- R8: `lk_way` reports the way index. `lk_target` is byte (way mod 8) of the target list, where byte 0 is bits [7:0].
- R9: The way index is the chunk index modulo the way count. For 3, 6 and 12 ways this is a true remainder.
- R10: On a hit, `lk_expander` equals control bit 10.
- R11: Reset clears all four registers and the committed, error and lock state.
- R12: `rd_data` returns the selected register one cycle after `rd_sel`. The selects are 0 for the window start, 1 for the window length, 2 for control and 3 for the target list. The start and length are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 64 | Register write value |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | 64 | Registered read value |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup address |
| lk_hit | output | 1 | Address lies inside the committed window |
| lk_way | output | 4 | Owning interleave way |
| lk_target | output | 8 | Port identifier for that way |
| lk_expander | output | 1 | Target class of the hit |

## Verification
A wrong commit or lock state shows up directly in control bits 11 and 12 on the read that follows the write. It also shows up one cycle after the next lookup, as a hit that should not happen or a miss that should be a hit. A wrong way index or granule shift is exposed by walking consecutive granules across the window for each way code, including the three-based counts. Each such step gives a wrong `lk_way` and `lk_target` on the very next cycle. The window edges at start − 1, start, start + length − 1 and start + length catch off-by-one errors in the range compare.

// File: rtl/imd_pkg.sv
package imd_pkg;
  localparam int TL_W  = 64;
  localparam int TID_W = 8;

  typedef enum logic [1:0] {
    REG_BASE = 2'd0,
    REG_SIZE = 2'd1,
    REG_CTRL = 2'd2,
    REG_TGT  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       ok;
    logic       by3;
    logic [2:0] k;
  } ways_dec_t;

  function automatic ways_dec_t decode_ways(input logic [3:0] c);
    ways_dec_t d;
    d = '0;
    if (c <= 4'd4) begin
      d.ok = 1'b1; d.k = c[2:0];
    end else if (c >= 4'd8 && c <= 4'd10) begin
      d.ok = 1'b1; d.by3 = 1'b1; d.k = 3'(c - 4'd8);
    end
    return d;
  endfunction

  function automatic logic [4:0] way_count(input ways_dec_t d);
    if (!d.ok) return 5'd0;
    return d.by3 ? (5'd3 << d.k) : (5'd1 << d.k);
  endfunction

  // serial remainder by three, most significant bit first
  function automatic logic [1:0] mod3(input logic [63:0] v);
    logic [1:0] r;
    logic [2:0] t;
    r = 2'd0;
    for (int i = 63; i >= 0; i--) begin
      t = {r, v[i]};
      r = (t >= 3'd3) ? 2'(t - 3'd3) : t[1:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/imd_regfile.sv
module imd_regfile
  import imd_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [TL_W-1:0]   wr_data,
  input  logic [1:0]        rd_sel,
  output logic [TL_W-1:0]   rd_data,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] size_o,
  output logic [3:0]        gran_o,
  output logic [3:0]        ways_o,
  output logic              type_o,
  output logic [TL_W-1:0]   tl_o,
  output logic              win_en_o
);
  localparam int CTRL_W = 13;

  logic [ADDR_W-1:0] base_q, size_q;
  logic [TL_W-1:0]   tl_q;
  logic [3:0]        gran_q, ways_q;
  logic              lock_q, creq_q, type_q, cmt_q, err_q;
  logic              locked, range_ok, new_ok, cfg_ok;
  logic [TL_W-1:0]   rd_q;

  assign locked   = cmt_q & lock_q;
  assign range_ok = (base_q != '1) && (size_q != '1);
  assign new_ok   = decode_ways(wr_data[7:4]).ok && range_ok;
  assign cfg_ok   = decode_ways(ways_q).ok && range_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0; size_q <= '0; tl_q <= '0;
      gran_q <= '0; ways_q <= '0;
      lock_q <= 1'b0; creq_q <= 1'b0; type_q <= 1'b0;
      cmt_q  <= 1'b0; err_q  <= 1'b0;
    end else if (wr_en && !locked) begin
      case (reg_sel_e'(wr_sel))
        REG_BASE: base_q <= wr_data[ADDR_W-1:0];
        REG_SIZE: size_q <= wr_data[ADDR_W-1:0];
        REG_TGT:  tl_q   <= wr_data;
        default: begin
          gran_q <= wr_data[3:0];
          ways_q <= wr_data[7:4];
          lock_q <= wr_data[8];
          creq_q <= wr_data[9];
          type_q <= wr_data[10];
          if (wr_data[9] && !creq_q) begin
            cmt_q <= new_ok;
            err_q <= !new_ok;
          end else if (!wr_data[9]) begin
            cmt_q <= 1'b0;
            err_q <= 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      case (reg_sel_e'(rd_sel))
        REG_BASE: rd_q <= TL_W'(base_q);
        REG_SIZE: rd_q <= TL_W'(size_q);
        REG_TGT:  rd_q <= tl_q;
        default:  rd_q <= TL_W'({err_q, cmt_q, type_q, creq_q, lock_q, ways_q, gran_q});
      endcase
    end
  end

  assign rd_data  = rd_q;
  assign base_o   = base_q;
  assign size_o   = size_q;
  assign gran_o   = gran_q;
  assign ways_o   = ways_q;
  assign type_o   = type_q;
  assign tl_o     = tl_q;
  assign win_en_o = cmt_q & cfg_ok;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst) locked |=> locked); // R7
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    locked |=> ($stable(base_q) && $stable(size_q) && $stable(tl_q) && $stable(ways_q))); // R7
  AST_COMMIT_ANSWER: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd2 && wr_data[9] && !creq_q && !locked) |=> (cmt_q != err_q)); // R5
  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd2 && !wr_data[9] && !locked) |=> (!cmt_q && !err_q)); // R6
endmodule

// File: rtl/imd_lookup.sv
module imd_lookup
  import imd_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] size_i,
  input  logic [3:0]        gran_i,
  input  logic [3:0]        ways_i,
  input  logic              type_i,
  input  logic [TL_W-1:0]   tl_i,
  input  logic              win_en_i,
  output logic              hit_o,
  output logic [3:0]        way_o,
  output logic [TID_W-1:0]  tgt_o,
  output logic              exp_o
);
  localparam int SH_BASE = 8;

  ways_dec_t         dec;
  logic [ADDR_W-1:0] off;
  logic [63:0]       chunk, mask, hi;
  logic [4:0]        sh;
  logic [4:0]        nways;
  logic [1:0]        m3;
  logic [3:0]        way_c;
  logic              in_win, hit_c;

  logic              hit_q, exp_q;
  logic [3:0]        way_q;
  logic [TID_W-1:0]  tgt_q;

  always_comb begin
    dec    = decode_ways(ways_i);
    nways  = way_count(dec);
    off    = addr_i - base_i;
    in_win = (addr_i >= base_i) && (off < size_i);
    sh     = 5'(gran_i) + 5'(SH_BASE);
    chunk  = 64'(off) >> sh;
    mask   = (64'd1 << dec.k) - 64'd1;
    hi     = chunk >> dec.k;
    m3     = mod3(hi);
    if (dec.by3) way_c = 4'((64'(m3) << dec.k) | (chunk & mask));
    else         way_c = 4'(chunk & mask);
    hit_c  = valid_i && win_en_i && dec.ok && in_win;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0; way_q <= '0; tgt_q <= '0; exp_q <= 1'b0;
    end else begin
      hit_q <= hit_c;
      way_q <= hit_c ? way_c : 4'd0;
      tgt_q <= hit_c ? tl_i[{way_c[2:0], 3'b000} +: TID_W] : '0;
      exp_q <= hit_c ? type_i : 1'b0;
    end
  end

  assign hit_o = hit_q;
  assign way_o = way_q;
  assign tgt_o = tgt_q;
  assign exp_o = exp_q;

  AST_NO_HIT_CLOSED: assert property (@(posedge clk) disable iff (rst) !win_en_i |=> !hit_o); // R3
  AST_BAD_WAYS_MISS: assert property (@(posedge clk) disable iff (rst) (nways == 5'd0) |=> !hit_o); // R2
  AST_WAY_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (5'(way_o) < $past(nways))); // R9
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (way_o == 4'd0 && tgt_o == '0 && !exp_o)); // R4
endmodule

// File: rtl/imd_decoder.sv
module imd_decoder
  import imd_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [63:0]       wr_data,
  input  logic [1:0]        rd_sel,
  output logic [63:0]       rd_data,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [3:0]        lk_way,
  output logic [7:0]        lk_target,
  output logic              lk_expander
);
  logic [ADDR_W-1:0] base_w, size_w;
  logic [3:0]        gran_w, ways_w;
  logic              type_w, win_en_w;
  logic [TL_W-1:0]   tl_w;

  imd_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .base_o(base_w), .size_o(size_w), .gran_o(gran_w), .ways_o(ways_w),
    .type_o(type_w), .tl_o(tl_w), .win_en_o(win_en_w)
  );

  imd_lookup #(.ADDR_W(ADDR_W)) u_look (
    .clk(clk), .rst(rst), .valid_i(lk_valid), .addr_i(lk_addr),
    .base_i(base_w), .size_i(size_w), .gran_i(gran_w), .ways_i(ways_w),
    .type_i(type_w), .tl_i(tl_w), .win_en_i(win_en_w),
    .hit_o(lk_hit), .way_o(lk_way), .tgt_o(lk_target), .exp_o(lk_expander)
  );
endmodule

// File: tb/sim_imd_decoder.sv
module sim_imd_decoder;
  localparam int ADDR_W = 48;
  localparam logic [63:0] TLIST = 64'h8877665544332211;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [63:0] rd_data;
  logic lk_valid = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic lk_hit, lk_expander;
  logic [3:0] lk_way;
  logic [7:0] lk_target;

  int checks = 0;
  int errors = 0;

  logic [63:0] m_base, m_size;
  logic [3:0]  m_gran, m_ways;
  logic        m_type, m_cmt;

  always #2.5 clk = ~clk;

  imd_decoder #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_way(lk_way), .lk_target(lk_target), .lk_expander(lk_expander)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic int nw(input logic [3:0] c);
    case (c)
      4'd0: return 1;  4'd1: return 2;  4'd2: return 4;
      4'd3: return 8;  4'd4: return 16; 4'd8: return 3;
      4'd9: return 6;  4'd10: return 12;
      default: return 0;
    endcase
  endfunction

  function automatic logic [63:0] cv(input logic [3:0] g, input logic [3:0] w,
                                     input logic lk, input logic cr, input logic ty);
    return {53'd0, ty, cr, lk, w, g};
  endfunction

  task automatic wr(input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [63:0] v);
    rd_sel = s;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic setup(input logic [63:0] b, input logic [63:0] sz,
                       input logic [3:0] g, input logic [3:0] w, input logic ty, input logic lk);
    wr(2'd2, cv(g, w, 1'b0, 1'b0, ty));
    wr(2'd0, b);
    wr(2'd1, sz);
    wr(2'd3, TLIST);
    wr(2'd2, cv(g, w, lk, 1'b1, ty));
    m_base = b; m_size = sz; m_gran = g; m_ways = w; m_type = ty;
    m_cmt = (nw(w) != 0) && (b[ADDR_W-1:0] != '1) && (sz[ADDR_W-1:0] != '1);
  endtask

  task automatic look(input string req, input logic [63:0] a);
    logic        eh;
    logic [63:0] off, way;
    off = a - m_base;
    eh = m_cmt && (nw(m_ways) != 0) && (a >= m_base) && (off < m_size);
    way = eh ? ((off >> (8 + m_gran)) % 64'(nw(m_ways))) : 64'd0;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a[ADDR_W-1:0];
    @(negedge clk);
    lk_valid = 1'b0;
    chk({req, " hit"}, 64'(lk_hit), 64'(eh));
    chk({req, " way"}, 64'(lk_way), way);
    chk({req, " target"}, 64'(lk_target), eh ? ((TLIST >> (8 * (way % 8))) & 64'hFF) : 64'd0);
    chk({req, " class R10"}, 64'(lk_expander), eh ? 64'(m_type) : 64'd0);
  endtask

  task automatic t_reset;
    logic [63:0] v;
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk("R11 reset reg", v, 64'd0);
    end
    m_base = 0; m_size = 0; m_gran = 0; m_ways = 0; m_type = 0; m_cmt = 0;
    look("R3 reset", 64'h0);
  endtask

  task automatic t_uncommitted;
    logic [63:0] v;
    wr(2'd2, cv(4'd0, 4'd1, 1'b0, 1'b0, 1'b0));
    wr(2'd0, 64'h40000);
    wr(2'd1, 64'h10000);
    wr(2'd3, TLIST);
    m_base = 64'h40000; m_size = 64'h10000; m_ways = 4'd1; m_cmt = 0;
    rd(2'd0, v); chk("R12 base readback", v, 64'h40000);
    rd(2'd1, v); chk("R12 size readback", v, 64'h10000);
    rd(2'd3, v); chk("R12 target readback", v, TLIST);
    rd(2'd2, v); chk("R12 ctrl readback", v, cv(4'd0, 4'd1, 1'b0, 1'b0, 1'b0));
    look("R3 uncommitted", 64'h40000);
  endtask

  task automatic t_walk(input string req, input logic [3:0] g, input logic [3:0] w,
                        input logic ty, input int steps);
    logic [63:0] v, gs;
    setup(64'h12340000, 64'h100000, g, w, ty, 1'b0);
    rd(2'd2, v);
    chk({req, " R5 committed"}, (v >> 11) & 64'h3, 64'h1);
    gs = 64'd256 << g;
    for (int i = 0; i < steps; i++) look(req, m_base + gs * 64'(i) + 64'd5);
  endtask

  task automatic t_edges;
    setup(64'h12340000, 64'h10000, 4'd0, 4'd2, 1'b0, 1'b0);
    look("R4 below", m_base - 64'd1);
    look("R4 start", m_base);
    look("R4 last", m_base + m_size - 64'd1);
    look("R4 past end", m_base + m_size);
  endtask

  task automatic t_gran;
    setup(64'h200000, 64'h100000, 4'd5, 4'd1, 1'b0, 1'b0);
    look("R1 granule end", m_base + 64'd8191);
    look("R1 next granule", m_base + 64'd8192);
    look("R1 third granule", m_base + 64'd16384);
  endtask

  task automatic t_uncommit;
    logic [63:0] v;
    setup(64'h12340000, 64'h10000, 4'd0, 4'd0, 1'b0, 1'b0);
    look("R6 before drop", m_base);
    wr(2'd2, cv(4'd0, 4'd0, 1'b0, 1'b0, 1'b0));
    m_cmt = 0;
    rd(2'd2, v);
    chk("R6 committed cleared", (v >> 11) & 64'h3, 64'h0);
    look("R6 after drop", m_base);
  endtask

  task automatic t_bad;
    logic [63:0] v;
    setup(64'h12340000, 64'h10000, 4'd0, 4'd5, 1'b0, 1'b0);
    rd(2'd2, v);
    chk("R2 bad way code error", (v >> 11) & 64'h3, 64'h2);
    look("R2 bad way code", m_base);
    setup(64'h12340000, 64'h10000, 4'd0, 4'd11, 1'b0, 1'b0);
    rd(2'd2, v);
    chk("R2 way code 11 error", (v >> 11) & 64'h3, 64'h2);
    setup(64'h1000, 64'hFFFF_FFFF_FFFF, 4'd0, 4'd0, 1'b0, 1'b0);
    rd(2'd2, v);
    chk("R5 size all ones error", (v >> 11) & 64'h3, 64'h2);
    look("R5 size all ones", 64'h1000);
    setup(64'hFFFF_FFFF_FFFF, 64'h100, 4'd0, 4'd0, 1'b0, 1'b0);
    rd(2'd2, v);
    chk("R5 base all ones error", (v >> 11) & 64'h3, 64'h2);
    wr(2'd2, cv(4'd0, 4'd0, 1'b0, 1'b0, 1'b0));
    rd(2'd2, v);
    chk("R6 error cleared", (v >> 11) & 64'h3, 64'h0);
  endtask

  task automatic t_lock;
    logic [63:0] v;
    wr(2'd2, cv(4'd0, 4'd0, 1'b1, 1'b0, 1'b0));
    wr(2'd0, 64'h5000);
    rd(2'd0, v);
    chk("R7 lock needs commit", v, 64'h5000);
    setup(64'h12340000, 64'h10000, 4'd0, 4'd1, 1'b1, 1'b1);
    wr(2'd0, 64'h9999000);
    wr(2'd1, 64'h20);
    wr(2'd3, 64'h0);
    wr(2'd2, cv(4'd3, 4'd3, 1'b0, 1'b0, 1'b0));
    rd(2'd0, v); chk("R7 base frozen", v, 64'h12340000);
    rd(2'd1, v); chk("R7 size frozen", v, 64'h10000);
    rd(2'd3, v); chk("R7 targets frozen", v, TLIST);
    rd(2'd2, v); chk("R7 ctrl frozen", v, (64'd1 << 11) | cv(4'd0, 4'd1, 1'b1, 1'b1, 1'b1));
    look("R7 locked still hits", m_base + 64'h100);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_cmt = 0;
    rd(2'd2, v); chk("R11 reset clears lock", v, 64'd0);
    rd(2'd0, v); chk("R11 reset clears base", v, 64'd0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_uncommitted();
    t_edges();
    t_walk("R9 R8 four ways", 4'd0, 4'd2, 1'b0, 10);
    t_walk("R9 R8 three ways", 4'd2, 4'd8, 1'b1, 9);
    t_walk("R9 R8 six ways", 4'd1, 4'd9, 1'b0, 14);
    t_walk("R9 R8 twelve ways", 4'd0, 4'd10, 1'b1, 26);
    t_walk("R9 R8 sixteen ways", 4'd0, 4'd4, 1'b0, 20);
    t_walk("R2 one way", 4'd3, 4'd0, 1'b1, 4);
    t_gran();
    t_uncommit();
    t_bad();
    t_lock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule